// File: doc/BRIEF.md
# Search Window Reuse Buffer

This block keeps the reference pixels that a full-search block-matching core needs for one N x N current block, with candidate displacements from -P to +P-1 on both axes. The stored window is 2P+N-1 reference rows tall and 2P+N-1 reference columns wide. A matching core asks for one window column per cycle by its offset from the left edge of the current search window. It gets all 2P+N-1 pixels of that column back in the next cycle.

When the encoder steps right to the next block in the same block row, the columns that the two windows share stay in place. Only the N newly uncovered columns are fetched through a pixel-read request/response interface. The columns sit in a circular buffer behind a base pointer, so a step moves the pointer and no stored pixel is moved. A start-of-row pulse drops every stored column and fetches a whole new window, because nothing is shared between block rows. Reference coordinates that fall outside the frame are clamped to the nearest edge pixel before they are requested, so the buffer holds padded data. Each column carries a valid flag. A read of a column that is still loading is held off through a ready signal.

Top module: `swb_reuse_buf`

## Requirements
- R1: After reset no column is valid, `rd_ready` is low for every offset, `rd_vld` is low and `mem_req_valid` is low.
- R2: A `row_start` pulse loads the whole window: exactly (2P+N-1)*(2P+N-1) pixel requests, column by column from offset 0, and top row to bottom row within each column.
- R3: A `next_blk` pulse advances the window by N pixels to the right and issues exactly N*(2P+N-1) pixel requests, all for the rightmost N offsets (2P-1 through 2P+N-2).
- R4: After `next_blk`, offsets 0 through 2P-2 hold the previous window's offsets N through 2P+N-2. They are readable in the cycle after the pulse, before any new pixel arrives.
- R5: A column whose load has begun but not finished reports `rd_ready` low. A read request made while `rd_ready` is low is not accepted and produces no `rd_vld`.
- R6: Window pixel (offset c, row r) of a block at horizontal position bx, in a block row whose top is at y0, is the frame pixel at x = clamp(bx-P+c, 0, FRAME_W-1) and y = clamp(y0-P+r, 0, FRAME_H-1). Every coordinate presented on `mem_req_x`/`mem_req_y` lies inside the frame.
- R7: A read accepted at a clock edge (`rd_req` and `rd_ready` high) sets `rd_vld` after that edge and places the column on `rd_col`, with row r at bits [r*PIX_W +: PIX_W] and row 0 the topmost row.
- R8: Window contents stay correct across any number of steps along a block row, including steps where the base pointer wraps around the buffer width.
- R9: `row_start` clears every valid flag in the next cycle, so offset 0 is not ready right after the pulse, and it restarts horizontal position at 0 for the new block row.
- R10: A request counts only in a cycle where `mem_req_valid` and `mem_req_ready` are both high. While a request waits, its coordinates hold steady. Responses come back in request order, one per `mem_resp_valid` cycle, with any latency.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| row_start | input | 1 | Pulse: begin a new block row, load the full window |
| row_y | input | YW | Top pixel row of the new block row, sampled with `row_start` |
| next_blk | input | 1 | Pulse: step to the next block, fetch N new columns |
| mem_req_valid | output | 1 | Pixel read request present |
| mem_req_ready | input | 1 | Memory accepts the request this cycle |
| mem_req_x | output | XW | Clamped frame column of the request |
| mem_req_y | output | YW | Clamped frame row of the request |
| mem_resp_valid | input | 1 | Returned pixel present |
| mem_resp_pix | input | PIX_W | Returned pixel value |
| rd_req | input | 1 | Matching core column read request |
| rd_off | input | OFF_W | Column offset within the current search window |
| rd_ready | output | 1 | Addressed column is fully loaded |
| rd_vld | output | 1 | `rd_col` holds the column of the last accepted read |
| rd_col | output | WIN*PIX_W | All rows of the column read, row 0 in the low bits |

## Verification
The embedded assertions assume three things about the inputs. `row_start` and `next_blk` come only while no load is in progress. Memory responses answer earlier requests and never arrive unprompted. `rd_off` stays below the window width. The stimulus sends each command only after it has read every window column, and the last column finishes loading last. Its memory model returns only pixels it has accepted, and it gates `mem_req_ready` and `mem_resp_valid` on fixed cycle patterns, so requests wait and responses arrive late. All read offsets lie between 0 and 2P+N-2.

// File: rtl/swb_pkg.sv
package swb_pkg;

    localparam int BLK_N   = 4;
    localparam int SRCH_P  = 4;
    localparam int PIX_W   = 8;
    localparam int FRAME_W = 16;
    localparam int FRAME_H = 12;
    localparam int COORD_W = 16;

    localparam int WIN   = 2 * SRCH_P + BLK_N - 1;
    localparam int OFF_W = $clog2(WIN);
    localparam int XW    = $clog2(FRAME_W);
    localparam int YW    = $clog2(FRAME_H);
    localparam int REUSE = 2 * SRCH_P - 1;

    typedef logic [PIX_W-1:0]          pix_t;
    typedef logic [OFF_W-1:0]          off_t;
    typedef logic [XW-1:0]             fx_t;
    typedef logic [YW-1:0]             fy_t;
    typedef logic signed [COORD_W-1:0] coord_t;
    typedef logic [WIN*PIX_W-1:0]      col_t;

    typedef struct packed {
        off_t   first;
        off_t   last;
        off_t   base;
        coord_t x0;
        coord_t y0;
    } job_t;

    function automatic int clamp_edge(int v, int hi);
        if (v < 0)  return 0;
        if (v > hi) return hi;
        return v;
    endfunction

    function automatic off_t wrap_add(off_t a, off_t b);
        int s;
        s = int'(a) + int'(b);
        if (s >= WIN) s = s - WIN;
        return off_t'(s);
    endfunction

endpackage

// File: rtl/swb_loader.sv
module swb_loader
    import swb_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic start,
    input  job_t job,
    output logic mem_req_valid,
    input  logic mem_req_ready,
    output fx_t  mem_req_x,
    output fy_t  mem_req_y,
    input  logic mem_resp_valid,
    input  pix_t mem_resp_pix,
    output logic wr_en,
    output off_t wr_col,
    output off_t wr_row,
    output pix_t wr_pix,
    output logic col_done,
    output logic busy
);

    job_t job_q;
    logic busy_q, rq_done;
    off_t rq_off, rq_row, wr_off, wr_row_q;

    assign busy          = busy_q;
    assign mem_req_valid = busy_q && !rq_done;
    assign mem_req_x     = fx_t'(clamp_edge(int'(job_q.x0) + int'(rq_off), FRAME_W - 1));
    assign mem_req_y     = fy_t'(clamp_edge(int'(job_q.y0) + int'(rq_row), FRAME_H - 1));

    assign wr_en    = mem_resp_valid;
    assign wr_col   = wrap_add(job_q.base, wr_off);
    assign wr_row   = wr_row_q;
    assign wr_pix   = mem_resp_pix;
    assign col_done = mem_resp_valid && (wr_row_q == off_t'(WIN - 1));

    always_ff @(posedge clk) begin
        if (rst) begin
            job_q    <= '0;
            busy_q   <= 1'b0;
            rq_done  <= 1'b0;
            rq_off   <= '0;
            rq_row   <= '0;
            wr_off   <= '0;
            wr_row_q <= '0;
        end else if (start) begin
            job_q    <= job;
            busy_q   <= 1'b1;
            rq_done  <= 1'b0;
            rq_off   <= job.first;
            rq_row   <= '0;
            wr_off   <= job.first;
            wr_row_q <= '0;
        end else begin
            if (mem_req_valid && mem_req_ready) begin
                if (rq_row == off_t'(WIN - 1)) begin
                    rq_row <= '0;
                    if (rq_off == job_q.last) rq_done <= 1'b1;
                    else                      rq_off  <= rq_off + 1'b1;
                end else begin
                    rq_row <= rq_row + 1'b1;
                end
            end
            if (mem_resp_valid) begin
                if (col_done) begin
                    wr_row_q <= '0;
                    if (wr_off == job_q.last) busy_q <= 1'b0;
                    else                      wr_off <= wr_off + 1'b1;
                end else begin
                    wr_row_q <= wr_row_q + 1'b1;
                end
            end
        end
    end

    assert_req_hold_R10: assert property (@(posedge clk) disable iff (rst)
        (mem_req_valid && !mem_req_ready && !start) |=>
            (mem_req_valid && $stable(mem_req_x) && $stable(mem_req_y)));

    assert_req_in_frame_R6: assert property (@(posedge clk) disable iff (rst)
        mem_req_valid |-> (int'(mem_req_x) < FRAME_W && int'(mem_req_y) < FRAME_H));

    assert_resp_only_when_loading_R10: assert property (@(posedge clk) disable iff (rst)
        mem_resp_valid |-> busy_q);

endmodule

// File: rtl/swb_colstore.sv
module swb_colstore
    import swb_pkg::*;
(
    input  logic           clk,
    input  logic           rst,
    input  logic [WIN-1:0] clr_mask,
    input  logic           wr_en,
    input  off_t           wr_col,
    input  off_t           wr_row,
    input  pix_t           wr_pix,
    input  logic           col_done,
    input  logic           rd_req,
    input  off_t           rd_phys,
    output logic           rd_ready,
    output logic           rd_vld,
    output col_t           rd_col
);

    pix_t           store [WIN][WIN];
    logic [WIN-1:0] valid_q, set_mask;
    col_t           rd_word;

    always_comb begin
        set_mask = '0;
        if (col_done) set_mask[wr_col] = 1'b1;
    end

    assign rd_ready = valid_q[rd_phys];

    for (genvar r = 0; r < WIN; r++) begin : g_pack
        assign rd_word[r*PIX_W +: PIX_W] = store[rd_phys][r];
    end

    always_ff @(posedge clk) begin
        if (wr_en) store[wr_col][wr_row] <= wr_pix;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            valid_q <= '0;
            rd_vld  <= 1'b0;
            rd_col  <= '0;
        end else begin
            valid_q <= (valid_q & ~clr_mask) | set_mask;
            rd_vld  <= rd_req && rd_ready;
            if (rd_req && rd_ready) rd_col <= rd_word;
        end
    end

    assert_clear_takes_effect_R9: assert property (@(posedge clk) disable iff (rst)
        (clr_mask != '0) |=> ((valid_q & $past(clr_mask)) == '0));

    assert_no_read_while_loading_R5: assert property (@(posedge clk) disable iff (rst)
        (rd_req && !rd_ready) |=> !rd_vld);

endmodule

// File: rtl/swb_reuse_buf.sv
module swb_reuse_buf
    import swb_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  row_start,
    input  logic [YW-1:0]         row_y,
    input  logic                  next_blk,
    output logic                  mem_req_valid,
    input  logic                  mem_req_ready,
    output logic [XW-1:0]         mem_req_x,
    output logic [YW-1:0]         mem_req_y,
    input  logic                  mem_resp_valid,
    input  logic [PIX_W-1:0]      mem_resp_pix,
    input  logic                  rd_req,
    input  logic [OFF_W-1:0]      rd_off,
    output logic                  rd_ready,
    output logic                  rd_vld,
    output logic [WIN*PIX_W-1:0]  rd_col
);

    coord_t         blk_x_q;
    off_t           base_q, base_n;
    fy_t            row_y_q;
    job_t           job;
    logic [WIN-1:0] clr_mask;
    logic           start, busy;
    logic           wr_en, col_done;
    off_t           wr_col, wr_row;
    pix_t           wr_pix;

    assign start  = row_start || next_blk;
    assign base_n = wrap_add(base_q, off_t'(BLK_N));

    always_comb begin
        job      = '0;
        clr_mask = '0;
        if (row_start) begin
            job.first = '0;
            job.last  = off_t'(WIN - 1);
            job.base  = '0;
            job.x0    = coord_t'(-SRCH_P);
            job.y0    = coord_t'(int'(row_y) - SRCH_P);
            clr_mask  = '1;
        end else if (next_blk) begin
            job.first = off_t'(REUSE);
            job.last  = off_t'(WIN - 1);
            job.base  = base_n;
            job.x0    = coord_t'(int'(blk_x_q) + BLK_N - SRCH_P);
            job.y0    = coord_t'(int'(row_y_q) - SRCH_P);
            for (int o = REUSE; o < WIN; o++)
                clr_mask[wrap_add(base_n, off_t'(o))] = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            blk_x_q <= '0;
            base_q  <= '0;
            row_y_q <= '0;
        end else if (row_start) begin
            blk_x_q <= '0;
            base_q  <= '0;
            row_y_q <= row_y;
        end else if (next_blk) begin
            blk_x_q <= blk_x_q + coord_t'(BLK_N);
            base_q  <= base_n;
        end
    end

    swb_loader i_loader (
        .clk            (clk),
        .rst            (rst),
        .start          (start),
        .job            (job),
        .mem_req_valid  (mem_req_valid),
        .mem_req_ready  (mem_req_ready),
        .mem_req_x      (mem_req_x),
        .mem_req_y      (mem_req_y),
        .mem_resp_valid (mem_resp_valid),
        .mem_resp_pix   (mem_resp_pix),
        .wr_en          (wr_en),
        .wr_col         (wr_col),
        .wr_row         (wr_row),
        .wr_pix         (wr_pix),
        .col_done       (col_done),
        .busy           (busy)
    );

    swb_colstore i_store (
        .clk      (clk),
        .rst      (rst),
        .clr_mask (clr_mask),
        .wr_en    (wr_en),
        .wr_col   (wr_col),
        .wr_row   (wr_row),
        .wr_pix   (wr_pix),
        .col_done (col_done),
        .rd_req   (rd_req),
        .rd_phys  (wrap_add(base_q, rd_off)),
        .rd_ready (rd_ready),
        .rd_vld   (rd_vld),
        .rd_col   (rd_col)
    );

    assert_cmd_only_when_idle_R2: assert property (@(posedge clk) disable iff (rst)
        (row_start || next_blk) |-> !busy);

    assert_single_cmd_R3: assert property (@(posedge clk) disable iff (rst)
        !(row_start && next_blk));

endmodule

// File: tb/test_swb_reuse_buf.sv
`timescale 1ns/1ps
module test_swb_reuse_buf;
    import swb_pkg::*;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic row_start = 1'b0, next_blk = 1'b0;
    logic [YW-1:0] row_y = '0;
    logic mem_req_valid, mem_req_ready = 1'b0;
    logic [XW-1:0] mem_req_x;
    logic [YW-1:0] mem_req_y;
    logic mem_resp_valid = 1'b0;
    logic [PIX_W-1:0] mem_resp_pix = '0;
    logic rd_req = 1'b0;
    logic [OFF_W-1:0] rd_off = '0;
    logic rd_ready, rd_vld;
    logic [WIN*PIX_W-1:0] rd_col;

    always #2.5 clk = ~clk;

    swb_reuse_buf i_swb_reuse_buf (.*);

    int n_checks = 0, n_fail = 0;
    int cyc = 0, req_count = 0;
    string cur_tag = "R7";
    logic [WIN*PIX_W-1:0] exp_q [$];
    pix_t pend_pix [$];
    int   pend_cyc [$];

    function automatic pix_t frame_pix(int x, int y);
        return pix_t'(x * 5 + y * 17 + 3);
    endfunction

    function automatic int edge_fix(int v, int hi);
        return (v < 0) ? 0 : ((v > hi) ? hi : v);
    endfunction

    // R6, R7: padded window column, row 0 in the low bits
    function automatic logic [WIN*PIX_W-1:0] ref_col(int bx, int ry, int off);
        logic [WIN*PIX_W-1:0] v;
        for (int r = 0; r < WIN; r++)
            v[r*PIX_W +: PIX_W] = frame_pix(edge_fix(bx - SRCH_P + off, FRAME_W - 1),
                                            edge_fix(ry - SRCH_P + r, FRAME_H - 1));
        return v;
    endfunction

    task automatic check(bit ok, string tag, int act, int expv);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, expv);
        end
    endtask

    // memory model (R10): gated acceptance and delayed in-order responses
    always @(negedge clk) begin
        cyc++;
        if (pend_pix.size() > 0 && pend_cyc[0] < cyc && (cyc % 4 != 2)) begin
            mem_resp_valid = 1'b1;
            mem_resp_pix   = pend_pix.pop_front();
            void'(pend_cyc.pop_front());
        end else begin
            mem_resp_valid = 1'b0;
        end
        mem_req_ready = (cyc % 3 != 1);
        if (mem_req_ready && mem_req_valid && !rst) begin
            pend_pix.push_back(frame_pix(int'(mem_req_x), int'(mem_req_y)));
            pend_cyc.push_back(cyc);
            req_count++;
        end
    end

    // monitor: compare each returned column with the scoreboard
    always @(negedge clk) begin
        if (!rst && rd_vld) begin
            if (exp_q.size() == 0) begin
                check(1'b0, cur_tag, 1, 0);
            end else begin
                logic [WIN*PIX_W-1:0] e;
                e = exp_q.pop_front();
                n_checks++;
                if (rd_col !== e) begin
                    n_fail++;
                    $display("FAIL %s actual=%h expected=%h", cur_tag, rd_col, e);
                end
            end
        end
    end

    task automatic probe(int off, bit exp_rdy, string tag);
        rd_off = off[OFF_W-1:0];
        #1;
        check(rd_ready === exp_rdy, tag, int'(rd_ready), int'(exp_rdy));
    endtask

    task automatic read_window(int bx, int ry);
        for (int off = 0; off < WIN; off++) begin
            rd_req = 1'b1;
            rd_off = off[OFF_W-1:0];
            #1;
            while (rd_ready !== 1'b1) begin
                @(negedge clk);
                #1;
            end
            exp_q.push_back(ref_col(bx, ry, off));
            @(negedge clk);
        end
        rd_req = 1'b0;
        repeat (2) @(negedge clk);
        check(exp_q.size() == 0, cur_tag, exp_q.size(), 0);
    endtask

    task automatic cmd_row(int ry);
        req_count = 0;
        row_y = ry[YW-1:0];
        row_start = 1'b1;
        @(negedge clk);
        row_start = 1'b0;
    endtask

    task automatic cmd_next();
        req_count = 0;
        next_blk = 1'b1;
        @(negedge clk);
        next_blk = 1'b0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (4) @(negedge clk);
        rst = 1'b0;
        // R1: reset state
        probe(0, 1'b0, "R1");
        probe(WIN - 1, 1'b0, "R1");
        check(rd_vld === 1'b0, "R1", int'(rd_vld), 0);
        check(mem_req_valid === 1'b0, "R1", int'(mem_req_valid), 0);

        // R2, R6: first block row at the top edge, full load with padding
        cmd_row(0);
        probe(0, 1'b0, "R9");
        cur_tag = "R6";
        read_window(0, 0);
        check(req_count == WIN * WIN, "R2", req_count, WIN * WIN);

        // R3, R4, R5, R8: step along the row; base pointer wraps on the third step
        for (int b = 1; b < FRAME_W / BLK_N; b++) begin
            cmd_next();
            probe(0, 1'b1, "R4");
            probe(WIN - 1, 1'b0, "R5");
            cur_tag = (b == 3) ? "R8" : "R4";
            read_window(b * BLK_N, 0);
            check(req_count == BLK_N * WIN, "R3", req_count, BLK_N * WIN);
        end

        // R9: new block row near the bottom edge, everything dropped and reloaded
        cmd_row(8);
        probe(0, 1'b0, "R9");
        probe(WIN - 1, 1'b0, "R9");
        cur_tag = "R9";
        read_window(0, 8);
        check(req_count == WIN * WIN, "R2", req_count, WIN * WIN);
        cmd_next();
        probe(REUSE - 1, 1'b1, "R4");
        cur_tag = "R10";
        read_window(BLK_N, 8);
        check(req_count == BLK_N * WIN, "R3", req_count, BLK_N * WIN);

        // R7: no read accepted while nothing is requested
        @(negedge clk);
        check(rd_vld === 1'b0, "R7", int'(rd_vld), 0);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
        $finish;
    end

endmodule